// File: doc/BRIEF.md
# Stop-Mode Wake Controller

This block decides when a device sleeping in STOP mode should wake up. Software sets it up through two write-only configuration registers. The primary register picks one of eight wake sources: none, a single port-3 pin (bits 0 to 3), port-2 bit 7, or a NOR over the low half or all of port 2. It also sets the wake polarity, turns on an optional recovery delay, and holds two clock-divider controls. The secondary register adds an AND over the low half or all of port 2 as another wake source.

The source comparison only happens while the stop-active input is high. A match passes through a two-flop synchroniser. The block then gives a single-cycle wake pulse, either on the next cycle or after a fixed number of clock-enable ticks. When a wake happens, the block sets a sticky recovery flag and clears the divide-by-16 control. A power-on reset is the only thing that clears the flag. Reading the flag therefore tells a cold start apart from a stop recovery.

Top module: `stop_wake_ctrl`

## Requirements
- R1: After power-on reset, wake_o, rec_flag_o, div16_o and clk_full_o are all 0.
- R2: Primary source field (write data bits 4:2) codes 001, 010, 011 and 100 select port-3 bits 0, 1, 2 and 3. Code 101 selects port-2 bit 7. A wake needs the selected value to equal the level bit.
- R3: Primary code 110 uses the NOR of port-2 bits 0 to 3. Code 111 uses the NOR of all eight port-2 bits.
- R4: The level bit (write data bit 6) chooses the active level of the source: 0 wakes on a 0 and 1 wakes on a 1.
- R5: With primary code 000 and secondary code 00 or 11, no pin pattern produces a wake.
- R6: Secondary register write data bits 1:0 select a source. Code 01 is the AND of port-2 bits 0 to 3, and code 10 is the AND of all port-2 bits. The source is compared with the level bit. Write data bits 7:2 of the secondary register have no effect.
- R7: No wake occurs while stop_act is 0, whatever the pins are.
- R8: With the delay bit (write data bit 5) at 0, a qualifying match is present from a rising edge. wake_o is then high for exactly one cycle, after the third rising edge.
- R9: With the delay bit at 1, the wake happens 16 tick_en cycles after the match leaves the synchroniser. Cycles in which tick_en is 0 do not advance the delay.
- R10: rec_flag_o goes to 1 on a wake and stays at 1 until power-on reset. Writes (including to bit 7) cannot change it.
- R11: Primary write data bit 0 drives div16_o and bit 1 drives clk_full_o. A wake clears div16_o and leaves clk_full_o unchanged.
- R12: Only one wake pulse is produced per stop episode. The controller rearms once stop_act returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| tick_en | input | 1 | Clock-enable tick that advances the recovery delay |
| wr_pri | input | 1 | Write strobe for the primary configuration register |
| wr_sec | input | 1 | Write strobe for the secondary configuration register |
| wr_data | input | 8 | Write data |
| stop_act | input | 1 | High while the device is in STOP |
| p2_in | input | 8 | Port 2 pin levels |
| p3_in | input | 8 | Port 3 pin levels |
| wake_o | output | 1 | One-cycle wake pulse |
| rec_flag_o | output | 1 | Recovery flag: 0 after power-on, 1 after a stop wake |
| div16_o | output | 1 | Divide-by-16 clock control |
| clk_full_o | output | 1 | 1: system clock at full crystal rate, 0: half rate |

## Verification
The bench drives stimulus at a falling edge and samples outputs at later falling edges. Without the delay, the wake pulse is due at the third falling edge after stop_act rises. With tick_en held high it is due at the nineteenth. With ticks withheld, it is due at the sixteenth falling edge after ticks resume. Each stop episode records a window of eight to twenty-two samples and compares the whole pattern, so a pulse that comes early, comes late, repeats or is missing is caught. The flag and divider outputs are sampled one falling edge after the write or wake edge that changes them.

// File: rtl/swk_pkg.sv
package swk_pkg;

  localparam int PORT_W = 8;

  typedef struct packed {
    logic       lvl;    // wake level
    logic       dly;    // recovery delay enable
    logic [2:0] src;    // primary source code
    logic       full;   // full-rate system clock
    logic       div16;  // divide-by-16 enable
  } pri_cfg_t;

  localparam pri_cfg_t PRI_RST = '{lvl: 1'b0, dly: 1'b1, src: 3'd0, full: 1'b0, div16: 1'b0};

  typedef enum logic [2:0] {
    SRC_NONE    = 3'd0,
    SRC_P3B0    = 3'd1,
    SRC_P3B1    = 3'd2,
    SRC_P3B2    = 3'd3,
    SRC_P3B3    = 3'd4,
    SRC_P2B7    = 3'd5,
    SRC_NOR_LO  = 3'd6,
    SRC_NOR_ALL = 3'd7
  } pri_src_e;

  typedef enum logic [1:0] {
    AND_NONE = 2'd0,
    AND_LO   = 2'd1,
    AND_ALL  = 2'd2,
    AND_RSVD = 2'd3
  } sec_src_e;

  typedef enum logic [1:0] {
    WK_IDLE = 2'd0,
    WK_WAIT = 2'd1,
    WK_DONE = 2'd2
  } wk_state_e;

  function automatic logic pri_valid(input logic [2:0] src);
    return pri_src_e'(src) != SRC_NONE;
  endfunction

  function automatic logic pri_value(input logic [2:0] src,
                                     input logic [PORT_W-1:0] p2,
                                     input logic [PORT_W-1:0] p3);
    logic v;
    case (pri_src_e'(src))
      SRC_P3B0:    v = p3[0];
      SRC_P3B1:    v = p3[1];
      SRC_P3B2:    v = p3[2];
      SRC_P3B3:    v = p3[3];
      SRC_P2B7:    v = p2[PORT_W-1];
      SRC_NOR_LO:  v = ~|p2[PORT_W/2-1:0];
      SRC_NOR_ALL: v = ~|p2;
      default:     v = 1'b0;
    endcase
    return v;
  endfunction

  function automatic logic sec_valid(input logic [1:0] sel);
    return (sec_src_e'(sel) == AND_LO) || (sec_src_e'(sel) == AND_ALL);
  endfunction

  function automatic logic sec_value(input logic [1:0] sel,
                                     input logic [PORT_W-1:0] p2);
    return (sec_src_e'(sel) == AND_ALL) ? (&p2) : (&p2[PORT_W/2-1:0]);
  endfunction

endpackage

// File: rtl/swk_cfg_regs.sv
module swk_cfg_regs
  import swk_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_pri,
  input  logic                wr_sec,
  input  logic [PORT_W-1:0]   wr_data,
  input  logic                fire,
  output pri_cfg_t            pri_q,
  output logic [1:0]          sec_q,
  output logic                rec_flag
);

  logic unused_wr_msb;
  assign unused_wr_msb = wr_data[PORT_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_q <= PRI_RST;
    end else begin
      if (wr_pri) pri_q <= pri_cfg_t'(wr_data[6:0]);
      if (fire)   pri_q.div16 <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sec_q <= 2'b00;
    else if (wr_sec) sec_q <= wr_data[1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rec_flag <= 1'b0;
    else if (fire) rec_flag <= 1'b1;
  end

  // R11
  div16_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !pri_q.div16);

  // R10
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_flag |=> rec_flag);

  // R10
  flag_on_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rec_flag);

endmodule

// File: rtl/swk_src_match.sv
module swk_src_match
  import swk_pkg::*;
(
  input  pri_cfg_t            pri,
  input  logic [1:0]          sec_sel,
  input  logic [PORT_W-1:0]   p2,
  input  logic [PORT_W-1:0]   p3,
  input  logic                stop_act,
  output logic                pri_hit,
  output logic                sec_hit,
  output logic                match
);

  logic unused_p3_hi;
  assign unused_p3_hi = ^p3[PORT_W-1:4];

  always_comb begin
    pri_hit = pri_valid(pri.src) && (pri_value(pri.src, p2, p3) == pri.lvl);
    sec_hit = sec_valid(sec_sel) && (sec_value(sec_sel, p2) == pri.lvl);
    match   = stop_act && (pri_hit || sec_hit);
  end

endmodule

// File: rtl/swk_wake_seq.sv
module swk_wake_seq
  import swk_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DLY_TICKS   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic match,
  input  logic stop_act,
  input  logic dly_en,
  input  logic tick_en,
  output logic synced,
  output logic fire,
  output logic wake
);

  localparam int CNT_W = $clog2(DLY_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DLY_TICKS - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  wk_state_e              state_q;
  logic [CNT_W-1:0]       cnt_q;
  logic                   fire_now;
  logic                   fire_late;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else        sync_q[g] <= match;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else        sync_q[g] <= sync_q[g-1];
      end
    end
  end

  assign synced    = sync_q[SYNC_STAGES-1];
  assign fire_now  = (state_q == WK_IDLE) && synced && stop_act && !dly_en;
  assign fire_late = (state_q == WK_WAIT) && stop_act && tick_en && (cnt_q == CNT_LAST);
  assign fire      = fire_now || fire_late;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WK_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        WK_IDLE: begin
          cnt_q <= '0;
          if (synced && stop_act) state_q <= dly_en ? WK_WAIT : WK_DONE;
        end
        WK_WAIT: begin
          if (!stop_act) begin
            state_q <= WK_IDLE;
          end else if (tick_en) begin
            if (cnt_q == CNT_LAST) state_q <= WK_DONE;
            else                   cnt_q   <= cnt_q + 1'b1;
          end
        end
        WK_DONE: begin
          if (!stop_act) state_q <= WK_IDLE;
        end
        default: state_q <= WK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake <= 1'b0;
    else        wake <= fire;
  end

  // R8
  wake_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);

  // R7
  wake_needs_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> $past(stop_act));

  // R9
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(DLY_TICKS));

  // R12
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WK_DONE) |-> !fire);

endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
  import swk_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DLY_TICKS   = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         wr_pri,
  input  logic         wr_sec,
  input  logic [7:0]   wr_data,
  input  logic         stop_act,
  input  logic [7:0]   p2_in,
  input  logic [7:0]   p3_in,
  output logic         wake_o,
  output logic         rec_flag_o,
  output logic         div16_o,
  output logic         clk_full_o
);

  pri_cfg_t   pri_q;
  logic [1:0] sec_q;
  logic       pri_hit;
  logic       sec_hit;
  logic       match;
  logic       synced;
  logic       fire;

  swk_cfg_regs u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_pri   (wr_pri),
    .wr_sec   (wr_sec),
    .wr_data  (wr_data),
    .fire     (fire),
    .pri_q    (pri_q),
    .sec_q    (sec_q),
    .rec_flag (rec_flag_o)
  );

  swk_src_match u_match (
    .pri      (pri_q),
    .sec_sel  (sec_q),
    .p2       (p2_in),
    .p3       (p3_in),
    .stop_act (stop_act),
    .pri_hit  (pri_hit),
    .sec_hit  (sec_hit),
    .match    (match)
  );

  swk_wake_seq #(
    .SYNC_STAGES (SYNC_STAGES),
    .DLY_TICKS   (DLY_TICKS)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .match    (match),
    .stop_act (stop_act),
    .dly_en   (pri_q.dly),
    .tick_en  (tick_en),
    .synced   (synced),
    .fire     (fire),
    .wake     (wake_o)
  );

  assign div16_o    = pri_q.div16;
  assign clk_full_o = pri_q.full;

  // R5
  no_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pri_valid(pri_q.src) && !sec_valid(sec_q)) |-> !match);

  // R7
  idle_no_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_act |-> !(match && (pri_hit || sec_hit) && !stop_act));

endmodule

// File: tb/stop_wake_ctrl_bench.sv
module stop_wake_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b1;
  logic       wr_pri = 1'b0;
  logic       wr_sec = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       stop_act = 1'b0;
  logic [7:0] p2_in = 8'h00;
  logic [7:0] p3_in = 8'h00;
  logic       wake_o, rec_flag_o, div16_o, clk_full_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  stop_wake_ctrl u_stop_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_pri(wr_pri), .wr_sec(wr_sec),
    .wr_data(wr_data), .stop_act(stop_act), .p2_in(p2_in), .p3_in(p3_in),
    .wake_o(wake_o), .rec_flag_o(rec_flag_o), .div16_o(div16_o), .clk_full_o(clk_full_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic write_reg(input bit to_sec, input logic [7:0] d);
    @(negedge clk);
    wr_pri = !to_sec; wr_sec = to_sec; wr_data = d;
    @(negedge clk);
    wr_pri = 1'b0; wr_sec = 1'b0; wr_data = 8'h00;
  endtask

  // raise stop, record wake over n samples, expect a pulse only at sample 'at' (0: none)
  task automatic episode(input int n, input int at, input string req);
    logic [31:0] got, exp;
    got = '0;
    exp = (at > 0) ? (32'd1 << (at - 1)) : 32'd0;
    @(negedge clk); stop_act = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      got[i] = wake_o;
    end
    chk(got == exp, req, got, exp);
    stop_act = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [7:0] p2_pick(input int i);
    case (i)
      0: return 8'h00; 1: return 8'hFF; 2: return 8'h0F; 3: return 8'hF0;
      4: return 8'h80; 5: return 8'h7F; 6: return 8'h01; default: return 8'hFE;
    endcase
  endfunction

  function automatic logic [7:0] p3_pick(input int j);
    case (j)
      0: return 8'h00; 1: return 8'hFF; 2: return 8'h05; default: return 8'h0A;
    endcase
  endfunction

  // independent model of the primary source: which bit, or a zero test
  function automatic bit exp_pri(input int src, input bit lvl, input logic [7:0] p2, input logic [7:0] p3);
    bit v;
    if (src == 0) return 1'b0;
    if (src <= 4)      v = p3[src - 1];
    else if (src == 5) v = p2[7];
    else if (src == 6) v = (p2 & 8'h0F) == 8'h00;
    else               v = p2 == 8'h00;
    return v == lvl;
  endfunction

  function automatic bit exp_sec(input int s, input bit lvl, input logic [7:0] p2);
    if (s == 1) return ((p2 & 8'h0F) == 8'h0F) == lvl;
    if (s == 2) return (p2 == 8'hFF) == lvl;
    return 1'b0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R8 actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R1
    chk({wake_o, rec_flag_o, div16_o, clk_full_o} == 4'b0, "R1 reset outputs",
        {wake_o, rec_flag_o, div16_o, clk_full_o}, 0);

    // primary sweep: R2 R3 R4 R5 R8 R12
    for (int src = 0; src < 8; src++) begin
      for (int lvl = 0; lvl < 2; lvl++) begin
        write_reg(1'b0, 8'((lvl << 6) | (src << 2)));
        for (int i = 0; i < 8; i++) begin
          for (int j = 0; j < 4; j++) begin
            p2_in = p2_pick(i); p3_in = p3_pick(j);
            episode(8, exp_pri(src, lvl[0], p2_in, p3_in) ? 3 : 0,
                    (src == 0) ? "R5 no source R8 R12" :
                    (src >= 6) ? "R3 NOR source R4 R8 R12" : "R2 pin source R4 R8 R12");
          end
        end
      end
    end

    // secondary sweep with reserved bits toggled: R6 R5
    for (int s = 0; s < 4; s++) begin
      for (int lvl = 0; lvl < 2; lvl++) begin
        for (int r = 0; r < 2; r++) begin
          write_reg(1'b0, 8'(lvl << 6));
          write_reg(1'b1, r ? 8'(8'hFC | s) : 8'(s));
          for (int i = 0; i < 8; i++) begin
            p2_in = p2_pick(i); p3_in = 8'h00;
            episode(8, exp_sec(s, lvl[0], p2_in) ? 3 : 0, "R6 AND source R5");
          end
        end
      end
    end
    write_reg(1'b1, 8'h00);

    // R7: matching pins with stop low
    write_reg(1'b0, 8'h04);
    p3_in = 8'h00;
    begin
      logic [31:0] seen;
      seen = '0;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        seen[k] = wake_o;
      end
      chk(seen == 0, "R7 stop inactive", seen, 0);
    end
    episode(8, 3, "R7 stop active wakes");

    // R9: delay with continuous ticks
    do_reset();
    tick_en = 1'b1;
    write_reg(1'b0, 8'h24);
    p3_in = 8'h00;
    episode(22, 19, "R9 delay 16 ticks");

    // R9: ticks withheld then resumed
    tick_en = 1'b0;
    @(negedge clk); stop_act = 1'b1;
    begin
      logic [31:0] g1, g2;
      g1 = '0; g2 = '0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk); g1[k] = wake_o;
      end
      chk(g1 == 0, "R9 no ticks no wake", g1, 0);
      tick_en = 1'b1;
      for (int k = 0; k < 18; k++) begin
        @(negedge clk); g2[k] = wake_o;
      end
      chk(g2 == (32'd1 << 15), "R9 ticks resumed", g2, 32'd1 << 15);
    end
    stop_act = 1'b0;
    repeat (4) @(negedge clk);

    // R10: flag sticky against writes, cleared by reset
    chk(rec_flag_o == 1'b1, "R10 flag after wake", rec_flag_o, 1);
    write_reg(1'b0, 8'h80);
    write_reg(1'b0, 8'h00);
    @(negedge clk);
    chk(rec_flag_o == 1'b1, "R10 flag ignores writes", rec_flag_o, 1);
    do_reset();
    @(negedge clk);
    chk(rec_flag_o == 1'b0, "R10 flag cleared by reset", rec_flag_o, 0);

    // R11: divider controls
    write_reg(1'b0, 8'h03);
    chk({div16_o, clk_full_o} == 2'b11, "R11 divider write", {div16_o, clk_full_o}, 2'b11);
    write_reg(1'b0, 8'h02);
    chk({div16_o, clk_full_o} == 2'b01, "R11 divider write low", {div16_o, clk_full_o}, 2'b01);
    write_reg(1'b0, 8'h07);
    p3_in = 8'h00;
    episode(8, 3, "R11 wake with div16");
    chk({div16_o, clk_full_o} == 2'b01, "R11 div16 cleared by wake", {div16_o, clk_full_o}, 2'b01);
    chk(rec_flag_o == 1'b1, "R10 flag set by wake", rec_flag_o, 1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule